// File: doc/BRIEF.md
# Speculative Register and Store Checkpoint Unit

This block holds the architectural state of a core that runs translated code blocks speculatively. Every architectural register is kept twice: a working copy that execution reads and writes, and a committed copy that is the last known-good state. Stores issued by speculative code do not go to memory directly. They wait in a small first-in, first-out store queue until the code block is declared good.

Two strobes close a block. A commit promotes the whole register file in one cycle and opens the gate on every store queued so far. Those stores then drain to memory in order, one per cycle. An abort copies the committed registers back over the working ones and drops every store that is still gated, also in one cycle. Memory is checkpointed this way without a second copy of RAM. While stores wait, loads search the queue from youngest to oldest, so speculative code sees its own writes.

One extra register has no shadow. Aborts do not touch it, so a value written there during a failed block survives the rollback.

Top module: `spec_state_unit`

## Requirements
- R1: After synchronous reset, all working and committed registers read 0, the store queue is empty, `st_stall` is 0 and `mem_wr_valid` is 0.
- R2: A register write (`wr_en`, `wr_idx`, `wr_data`) changes only the working copy. `rd_data` is registered and shows the working value of `rd_idx` as it stood before the clock edge that samples `rd_idx`.
- R3: `commit` copies every working register into its committed copy. It also closes the gate on all stores accepted before that edge. A store offered in the same cycle as `commit` stays gated.
- R4: `abort` restores every working register from its committed copy in one cycle. When `abort` and `commit` arrive together, `abort` wins.
- R5: The unshadowed register (`xr_we`, `xr_wdata`, `xr_q`) keeps its written value across an abort.
- R6: No store reaches the memory port before a commit. Committed stores appear on `mem_wr_*` in the order they were accepted, one per cycle. The first one appears in the cycle after the commit edge.
- R7: `abort` discards all gated stores at once. Stores already committed still drain.
- R8: `st_stall` is 1 whenever the queue holds `SB_DEPTH` entries. A store offered while `st_stall` is 1 is ignored.
- R9: A commit that arrives while a drain is in progress only moves the gate. Stores accepted after it stay gated until the next commit.
- R10: A load address `ld_addr` is matched against all queued stores, and the youngest match wins. `ld_hit` and `ld_data` are registered and appear one cycle later. `ld_hit` is 0 when nothing matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | Commit strobe |
| abort | input | 1 | Abort strobe |
| wr_en | input | 1 | Working register write enable |
| wr_idx | input | $clog2(NREG) | Register to write |
| wr_data | input | DW | Write data |
| rd_idx | input | $clog2(NREG) | Register to read |
| rd_data | output | DW | Registered working value |
| xr_we | input | 1 | Unshadowed register write enable |
| xr_wdata | input | DW | Unshadowed register data |
| xr_q | output | DW | Unshadowed register value |
| st_valid | input | 1 | Store enqueue request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Queue full, store not accepted |
| ld_addr | input | AW | Load address for forwarding |
| ld_hit | output | 1 | Registered forward hit |
| ld_data | output | DW | Registered forwarded data |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
Register rollback is tried with three sequences. Writes followed directly by an abort show that the working copy alone was touched. Write, commit, write, then abort shows that the restore targets the last commit and not reset. A commit followed by an abort shows that a commit is permanent. The store path is tried with a plain two-store commit, which checks order and spacing, and with two stores to one address, which tells youngest-first forwarding from oldest-first. Further sequences cover an abort while a drain is running, a commit during a drain, a store on the commit edge, and a store offered into a full queue; they separate gated entries from committed entries.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_COMMIT = 2'd1,
    EV_ABORT  = 2'd2
  } ssu_ev_e;

  // abort takes priority over a simultaneous commit
  function automatic ssu_ev_e resolve_ev(input logic c, input logic a);
    if (a) return EV_ABORT;
    if (c) return EV_COMMIT;
    return EV_NONE;
  endfunction
endpackage

// File: rtl/ssu_regfile.sv
module ssu_regfile
  import ssu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  ssu_ev_e       ev,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] work [NREG];
  logic [DW-1:0] comm [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        work[i] <= '0;
        comm[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ev == EV_ABORT) work[i] <= comm[i];
        else if (wr_en && wr_idx == IW'(i)) work[i] <= wr_data;
        if (ev == EV_COMMIT) comm[i] <= work[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= work[rd_idx];
  end
endmodule

// File: rtl/ssu_store_queue.sv
module ssu_store_queue
  import ssu_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ssu_ev_e       ev,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic [PW-1:0] n_total,
  output logic [PW-1:0] n_commit
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, gate, tail;
  logic          full, push, pop;
  logic          fw_hit;
  logic [DW-1:0] fw_data;

  assign n_total  = tail - head;
  assign n_commit = gate - head;
  assign full     = (n_total == PW'(DEPTH));
  assign st_stall = full;
  assign push     = st_valid && !full && (ev != EV_ABORT);
  assign pop      = (head != gate);

  // storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail[IW-1:0]] <= st_addr;
      data_q[tail[IW-1:0]] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      gate <= '0;
      tail <= '0;
    end else begin
      head <= head + PW'(pop);
      if (ev == EV_ABORT) tail <= gate;
      else                tail <= tail + PW'(push);
      if (ev == EV_COMMIT) gate <= tail;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      mem_wr_valid <= pop;
      mem_wr_addr  <= addr_q[head[IW-1:0]];
      mem_wr_data  <= data_q[head[IW-1:0]];
    end
  end

  // oldest to youngest scan; a later match overrides an earlier one
  always_comb begin
    fw_hit  = 1'b0;
    fw_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] p;
      p = head + PW'(i);
      if (PW'(i) < n_total && addr_q[p[IW-1:0]] == ld_addr) begin
        fw_hit  = 1'b1;
        fw_data = data_q[p[IW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else begin
      ld_hit  <= fw_hit;
      ld_data <= fw_data;
    end
  end
endmodule

// File: rtl/spec_state_unit.sv
module spec_state_unit
  import ssu_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int SB_DEPTH = 4,
  localparam int IW      = $clog2(NREG),
  localparam int PW      = $clog2(SB_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          abort,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          xr_we,
  input  logic [DW-1:0] xr_wdata,
  output logic [DW-1:0] xr_q,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  ssu_ev_e       ev;
  logic [PW-1:0] n_total;
  logic [PW-1:0] n_commit;

  assign ev = resolve_ev(commit, abort);

  ssu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .ev(ev),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  ssu_store_queue #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sq (
    .clk(clk), .rst(rst), .ev(ev),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_stall(st_stall),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .n_total(n_total), .n_commit(n_commit)
  );

  // unshadowed register: never rolled back
  always_ff @(posedge clk) begin
    if (rst)        xr_q <= '0;
    else if (xr_we) xr_q <= xr_wdata;
  end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          commit,
  input logic          abort,
  input logic          st_valid,
  input logic          st_stall,
  input logic          mem_wr_valid,
  input logic [PW-1:0] n_total,
  input logic [PW-1:0] n_commit
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_wr_valid && !st_stall && n_total == '0));

  a_r6_drain_needs_commit: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ($past(n_commit) != '0));

  a_r6_drain_each_cycle: assert property (@(posedge clk) disable iff (rst)
    (n_commit != '0) |=> mem_wr_valid);

  a_r7_abort_drops_gated: assert property (@(posedge clk) disable iff (rst)
    abort |=> (n_total == n_commit));

  a_r3_commit_opens_gate: assert property (@(posedge clk) disable iff (rst)
    (commit && !abort && !st_valid) |=> (n_total == n_commit));

  a_r8_full_stalls: assert property (@(posedge clk) disable iff (rst)
    (n_total == PW'(DEPTH)) |-> st_stall);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (n_total <= PW'(DEPTH)) && (n_commit <= n_total));
endmodule

bind spec_state_unit ssu_checker #(.DEPTH(SB_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .abort(abort),
  .st_valid(st_valid), .st_stall(st_stall), .mem_wr_valid(mem_wr_valid),
  .n_total(n_total), .n_commit(n_commit)
);

// File: tb/spec_state_unit_tb.sv
module spec_state_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int SB_DEPTH = 4;
  localparam int IW = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic commit = 0, abort = 0, wr_en = 0, xr_we = 0, st_valid = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [DW-1:0] wr_data = '0, xr_wdata = '0, st_data = '0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] rd_data, xr_q, ld_data, mem_wr_data;
  logic [AW-1:0] mem_wr_addr;
  logic st_stall, ld_hit, mem_wr_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_state_unit #(.NREG(NREG), .DW(DW), .AW(AW), .SB_DEPTH(SB_DEPTH)) u_dut (
    .clk(clk), .rst(rst), .commit(commit), .abort(abort),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .xr_we(xr_we), .xr_wdata(xr_wdata), .xr_q(xr_q),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, log_n = 0, commit_cyc = 0;
  logic [AW-1:0] log_addr [32];
  logic [DW-1:0] log_data [32];
  int            log_cyc  [32];

  always @(posedge clk) cyc <= cyc + 1;

  // memory write monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst && mem_wr_valid && log_n < 32) begin
      log_addr[log_n] = mem_wr_addr;
      log_data[log_n] = mem_wr_data;
      log_cyc[log_n]  = cyc;
      log_n = log_n + 1;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d;
    tick();
    st_valid = 0;
  endtask

  task automatic do_commit();
    commit = 1; tick(); commit = 0; commit_cyc = cyc;
  endtask

  task automatic do_abort();
    abort = 1; tick(); abort = 0;
  endtask

  task automatic load(input logic [AW-1:0] a);
    ld_addr = a; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // op: 0 write, 1 read-and-check, 2 commit, 3 abort
  typedef struct packed {
    logic [1:0]    op;
    logic [IW-1:0] idx;
    logic [DW-1:0] dat;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd0, 32'h0},          // R1 reset value
    '{2'd0, 3'd1, 32'h11},
    '{2'd0, 3'd2, 32'h22},
    '{2'd1, 3'd1, 32'h11},         // R2 working copy readable
    '{2'd3, 3'd0, 32'h0},
    '{2'd1, 3'd1, 32'h0},          // R4 restored to reset state
    '{2'd1, 3'd2, 32'h0},          // R4 all registers restored
    '{2'd0, 3'd1, 32'h33},
    '{2'd2, 3'd0, 32'h0},
    '{2'd0, 3'd1, 32'h44},
    '{2'd1, 3'd1, 32'h44},         // R2
    '{2'd3, 3'd0, 32'h0},
    '{2'd1, 3'd1, 32'h33},         // R3 and R4 restore to last commit
    '{2'd0, 3'd7, 32'h77},
    '{2'd2, 3'd0, 32'h0},
    '{2'd1, 3'd7, 32'h77}          // R3 commit survives the abort below? no abort yet
  };

  initial begin
    repeat (3) tick();
    rst = 0;
    chk("R1 st_stall", {31'd0, st_stall}, 32'd0);
    chk("R1 mem_wr_valid", {31'd0, mem_wr_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        2'd0: begin wr_en = 1; wr_idx = VECS[v].idx; wr_data = VECS[v].dat; tick(); wr_en = 0; end
        2'd1: begin rd_idx = VECS[v].idx; tick();
                    chk($sformatf("R2/R3/R4 vector %0d", v), rd_data, VECS[v].dat); end
        2'd2: do_commit();
        default: do_abort();
      endcase
    end
    do_abort();
    rd_idx = 3'd7; tick();
    chk("R3 commit is permanent", rd_data, 32'h77);

    // R4: abort wins over a simultaneous commit
    wr_en = 1; wr_idx = 3'd7; wr_data = 32'h99; tick(); wr_en = 0;
    commit = 1; abort = 1; tick(); commit = 0; abort = 0;
    rd_idx = 3'd7; tick();
    chk("R4 abort beats commit", rd_data, 32'h77);

    // R5 unshadowed register
    xr_we = 1; xr_wdata = 32'h5A; tick(); xr_we = 0;
    do_abort();
    chk("R5 unshadowed survives abort", xr_q, 32'h5A);

    // R6 gating and ordered drain
    push_st(16'h10, 32'hA1);
    push_st(16'h20, 32'hB2);
    idle(3);
    chk("R6 no write before commit", log_n, 0);
    load(16'h10);
    chk("R10 hit", {31'd0, ld_hit}, 32'd1);
    chk("R10 data", ld_data, 32'hA1);
    do_commit();
    idle(4);
    chk("R6 drained count", log_n, 2);
    chk("R6 first addr", {16'd0, log_addr[0]}, 32'h10);
    chk("R6 second data", log_data[1], 32'hB2);
    chk("R6 first drain cycle", log_cyc[0], commit_cyc + 1);
    chk("R6 one per cycle", log_cyc[1] - log_cyc[0], 1);

    // R10 youngest match, R7 discard
    push_st(16'h30, 32'h1);
    push_st(16'h30, 32'h2);
    push_st(16'h40, 32'h3);
    load(16'h30);
    chk("R10 youngest wins", ld_data, 32'h2);
    do_abort();
    load(16'h30);
    chk("R7 gated entries gone", {31'd0, ld_hit}, 32'd0);
    idle(3);
    chk("R7 nothing drained", log_n, 2);

    // R7 committed entries survive abort during drain
    push_st(16'h50, 32'h5);
    push_st(16'h60, 32'h6);
    do_commit();
    push_st(16'h70, 32'h7);
    do_abort();
    idle(4);
    chk("R7 committed still drain", log_n, 4);
    chk("R7 last drained addr", {16'd0, log_addr[3]}, 32'h60);

    // R9 commit during drain moves only the gate
    push_st(16'h80, 32'h80);
    push_st(16'h81, 32'h81);
    push_st(16'h82, 32'h82);
    do_commit();
    push_st(16'h90, 32'h90);
    idle(5);
    chk("R9 later store still gated", log_n, 7);
    load(16'h90);
    chk("R9 later store still queued", {31'd0, ld_hit}, 32'd1);
    do_commit();
    idle(3);
    chk("R9 drained after second commit", log_n, 8);
    chk("R9 addr", {16'd0, log_addr[7]}, 32'h90);

    // R8 full queue stalls and ignores a store
    for (int k = 0; k < SB_DEPTH; k++) push_st(AW'(16'hA0 + k), DW'(k));
    chk("R8 stall when full", {31'd0, st_stall}, 32'd1);
    push_st(16'hAF, 32'hFF);
    load(16'hAF);
    chk("R8 stalled store ignored", {31'd0, ld_hit}, 32'd0);
    do_commit();
    idle(6);
    chk("R8 drained count", log_n, 12);
    chk("R8 last addr", {16'd0, log_addr[11]}, 32'hA3);
    chk("R8 stall released", {31'd0, st_stall}, 32'd0);

    // R3 store on the commit edge stays gated
    st_valid = 1; st_addr = 16'hC0; st_data = 32'hC0; commit = 1;
    tick();
    st_valid = 0; commit = 0;
    idle(3);
    chk("R3 same-cycle store gated", log_n, 12);
    do_commit();
    idle(3);
    chk("R3 drains after next commit", log_n, 13);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R0 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule